// File: doc/BRIEF.md
# AFSK Tone Modulator with Byte Framing

This block turns a stream of bytes into audio samples that alternate between two tones at 1200 baud. It is clocked by the system clock and moves forward by one sample on each cycle where the sample-rate strobe is high. Bytes arrive over a valid/ready handshake into a two-entry holding buffer. A start pulse opens a transmission. The block first sends a preamble of flag bytes, then the payload, then trailer flags once the input has run dry, and after that it drops back to idle.

Each byte is sent least significant bit first with NRZI coding: a one keeps the tone, a zero swaps it. When five ones have been sent in a row, an extra zero is inserted. Raw 0x7E and 0x7F bytes go out with stuffing switched off, so that they can serve as flag and abort patterns. An escape byte 0x1B is not sent; it makes the byte after it go out with stuffing on. A tone change is made by changing the phase increment of a 512-step accumulator. The 8-bit unsigned output sample is rebuilt from a 128-entry quarter-wave table.

Top module: `afsk_tone_mod`

## Requirements
- R1: The mark increment is round(512·1200/SAMPLE_RATE) and the space increment is round(512·2200/SAMPLE_RATE). On every active strobe the 9-bit phase advances modulo 512 by the increment in force for that sample, and sample_o shows the sine of the new phase one clock later, with sample_valid_o high for exactly that one cycle.
- R2: For a phase p, let m = p mod 256, and replace m by 255−m when m ≥ 128. Then q = round(128 + 127·sin(2π·m/512)). The sample is q when p < 256 and 255−q otherwise.
- R3: A bit lasts SAMPLE_RATE/1200 strobes. Bytes go out LSB first. A 1 keeps the increment and a 0 swaps mark and space, with the decision made on the first strobe of the bit period.
- R4: While stuffing is on, a bit period that begins with five or more counted ones sends an extra tone swap and clears the count, and the pending data bit moves to the next period. A data 1 adds to the count and a data 0 clears it.
- R5: Raw 0x7E and 0x7F bytes, including preamble and trailer flags, are sent with stuffing off. The ones count is cleared at the start of a byte only when the byte before it was sent with stuffing off.
- R6: An escape byte 0x1B is dropped, and the byte after it is sent with stuffing on whatever its value. If no byte follows the escape when it is reached, transmission ends on that strobe.
- R7: PREAMBLE_BYTES flags come first. The payload follows. TRAILER_BYTES flags are sent only once the input is empty. The block goes idle (busy_o low, sample_o 0, no valid) on the strobe where a new byte is due, the input is empty and the trailer count is zero.
- R8: A start pulse while idle sets the mark increment, phase 0, a ones count of 0 and the preamble count, and raises busy_o on the next clock. Every start pulse reloads the trailer count. When a start pulse coincides with a strobe that takes a trailer flag, the reload wins, so TRAILER_BYTES further flags follow.
- R9: After reset busy_o is low, sample_o is 0, sample_valid_o is low and data_ready_o is high.
- R10: data_ready_o is high whenever fewer than two bytes are held. Bytes are used in arrival order and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate strobe |
| start_i | input | 1 | Start / trailer reload pulse |
| data_i | input | 8 | Byte to send |
| data_valid_i | input | 1 | Byte offered |
| data_ready_o | output | 1 | Byte accepted when high with valid |
| sample_o | output | 8 | Unsigned audio sample |
| sample_valid_o | output | 1 | One-cycle pulse with each new sample |
| busy_o | output | 1 | Transmission in progress |

## Verification
Two actions can fall on the same clock: a start pulse that reloads the trailer count, and a byte-boundary strobe that is taking a trailer flag and decrementing that count. The bench waits until its own model reaches the first trailer byte boundary, then raises start_i on the same cycle as that strobe. It judges the result from the number of flag periods that follow before busy_o falls and sample_valid_o stops, which must be one flag more than a frame without the reload. Every sample of every frame is also compared against a model built from the tone, stuffing and escape rules.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'h7F;
  localparam logic [7:0] ESC_BYTE   = 8'h1B;
  localparam int PHASE_W   = 9;
  localparam int STUFF_RUN = 5;
  localparam int BAUD      = 1200;
  localparam int MARK_HZ   = 1200;
  localparam int SPACE_HZ  = 2200;
endpackage

// File: rtl/afsk_byte_buf.sv
module afsk_byte_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] push_data_i,
  input  logic       push_valid_i,
  output logic       push_ready_o,
  input  logic [1:0] pop_n_i,
  output logic [7:0] head0_o,
  output logic [7:0] head1_o,
  output logic [1:0] count_o
);
  logic [7:0] e0_q, e1_q, e0_d, e1_d;
  logic [1:0] cnt_q, cnt_d, rem;
  logic       push;

  assign push_ready_o = cnt_q < 2'd2;
  assign push         = push_valid_i & push_ready_o;

  always_comb begin
    rem  = cnt_q - pop_n_i;
    e0_d = (pop_n_i == 2'd0) ? e0_q : e1_q;
    e1_d = e1_q;
    if (push) begin
      if (rem == 2'd0) e0_d = push_data_i;
      else             e1_d = push_data_i;
    end
    cnt_d = rem + {1'b0, push};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e0_q  <= '0;
      e1_q  <= '0;
      cnt_q <= '0;
    end else begin
      e0_q  <= e0_d;
      e1_q  <= e1_d;
      cnt_q <= cnt_d;
    end
  end

  assign head0_o = e0_q;
  assign head1_o = e1_q;
  assign count_o = cnt_q;

  // R10
  pop_within_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= cnt_q);
  // R10
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2);
endmodule

// File: rtl/afsk_nco.sv
module afsk_nco #(
  parameter int MARK_INC  = 64,
  parameter int SPACE_INC = 117
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       adv_i,
  input  logic       swap_i,
  output logic [8:0] phase_nxt_o
);
  localparam logic [8:0] MARK_V  = 9'(MARK_INC);
  localparam logic [8:0] SPACE_V = 9'(SPACE_INC);

  logic [8:0] inc_q, inc_nxt, phase_q;

  assign inc_nxt     = swap_i ? ((inc_q == MARK_V) ? SPACE_V : MARK_V) : inc_q;
  assign phase_nxt_o = phase_q + inc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q   <= MARK_V;
      phase_q <= '0;
    end else if (init_i) begin
      inc_q   <= MARK_V;
      phase_q <= '0;
    end else if (adv_i) begin
      inc_q   <= inc_nxt;
      phase_q <= phase_nxt_o;
    end
  end

  // R1
  two_tones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q == MARK_V || inc_q == SPACE_V);
  // R8
  init_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> phase_q == 9'd0 && inc_q == MARK_V);
endmodule

// File: rtl/afsk_sine_lut.sv
module afsk_sine_lut (
  input  logic [8:0] idx_i,
  output logic [7:0] smp_o
);
  function automatic logic [127:0][7:0] build_quarter();
    logic [127:0][7:0] t;
    real two_pi;
    two_pi = 6.283185307179586;
    for (int i = 0; i < 128; i++)
      t[i] = 8'($rtoi(128.0 + 127.0 * $sin(two_pi * i / 512.0) + 0.5));
    return t;
  endfunction

  localparam logic [127:0][7:0] QUARTER = build_quarter();

  logic [7:0] half_idx;
  logic [6:0] q_idx;
  logic [7:0] q_val;

  assign half_idx = idx_i[7:0];
  assign q_idx    = half_idx[7] ? 7'(8'd255 - half_idx) : half_idx[6:0];
  assign q_val    = QUARTER[q_idx];
  assign smp_o    = idx_i[8] ? (8'd255 - q_val) : q_val;
endmodule

// File: rtl/afsk_tone_mod.sv
module afsk_tone_mod #(
  parameter int SAMPLE_RATE    = 9600,
  parameter int PREAMBLE_BYTES = 4,
  parameter int TRAILER_BYTES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       data_valid_i,
  output logic       data_ready_o,
  output logic [7:0] sample_o,
  output logic       sample_valid_o,
  output logic       busy_o
);
  import afsk_pkg::*;

  localparam int SPB       = SAMPLE_RATE / BAUD;
  localparam int CW        = $clog2(SPB + 1);
  localparam int PW        = $clog2(PREAMBLE_BYTES + 2);
  localparam int TW        = $clog2(TRAILER_BYTES + 2);
  localparam int MARK_INC  = (512 * MARK_HZ + SAMPLE_RATE / 2) / SAMPLE_RATE;
  localparam int SPACE_INC = (512 * SPACE_HZ + SAMPLE_RATE / 2) / SAMPLE_RATE;

  logic          busy_q, stuff_q, valid_q;
  logic [CW-1:0] sc_q;
  logic [3:0]    bi_q, cnt_q, cnt_base;
  logic [7:0]    cur_q, smp_q;
  logic [PW-1:0] pre_q;
  logic [TW-1:0] trl_q;

  logic [7:0] head0, head1, byte_sel, cur_eff, lut_smp;
  logic [1:0] buf_cnt, pop_n;
  logic [8:0] phase_nxt;
  logic [3:0] bi_eff;
  logic act, bound, empty, use_flag, esc_hit, stop, new_bit, do_stuff;
  logic stuff_new, stuff_eff, data_bit, swap, adv, init;

  afsk_byte_buf u_buf (
    .clk_i, .rst_ni,
    .push_data_i (data_i),
    .push_valid_i(data_valid_i),
    .push_ready_o(data_ready_o),
    .pop_n_i     (pop_n),
    .head0_o     (head0),
    .head1_o     (head1),
    .count_o     (buf_cnt)
  );

  afsk_nco #(.MARK_INC(MARK_INC), .SPACE_INC(SPACE_INC)) u_nco (
    .clk_i, .rst_ni,
    .init_i     (init),
    .adv_i      (adv),
    .swap_i     (swap),
    .phase_nxt_o(phase_nxt)
  );

  afsk_sine_lut u_lut (.idx_i(phase_nxt), .smp_o(lut_smp));

  always_comb begin
    act       = tick_i & busy_q;
    bound     = act && sc_q == '0 && bi_q == 4'd8;
    empty     = buf_cnt == 2'd0;
    use_flag  = pre_q != '0 || empty;
    esc_hit   = !use_flag && head0 == ESC_BYTE;
    stop      = bound && ((empty && trl_q == '0) || (esc_hit && buf_cnt < 2'd2));
    pop_n     = (bound && !use_flag) ? ((esc_hit && buf_cnt == 2'd2) ? 2'd2 : 2'd1) : 2'd0;
    byte_sel  = use_flag ? FLAG_BYTE : (esc_hit ? head1 : head0);
    stuff_new = esc_hit || !(byte_sel == FLAG_BYTE || byte_sel == ABORT_BYTE);
    cur_eff   = bound ? byte_sel : cur_q;
    bi_eff    = bound ? 4'd0 : bi_q;
    stuff_eff = bound ? stuff_new : stuff_q;
    cnt_base  = (bound && !stuff_q) ? 4'd0 : cnt_q;
    new_bit   = act && sc_q == '0 && !stop;
    do_stuff  = new_bit && stuff_eff && cnt_base >= 4'(STUFF_RUN);
    data_bit  = cur_eff[bi_eff[2:0]];
    swap      = do_stuff || (new_bit && !data_bit);
    adv       = act && !stop;
    init      = start_i && !busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stuff_q <= 1'b0;
      valid_q <= 1'b0;
      sc_q    <= '0;
      bi_q    <= 4'd8;
      cnt_q   <= '0;
      cur_q   <= '0;
      smp_q   <= '0;
      pre_q   <= '0;
      trl_q   <= '0;
    end else begin
      valid_q <= adv;
      if (stop) begin
        busy_q <= 1'b0;
        smp_q  <= '0;
      end else if (adv) begin
        smp_q <= lut_smp;
      end
      if (new_bit) begin
        cnt_q <= do_stuff ? 4'd0 : (data_bit ? cnt_base + 4'd1 : 4'd0);
        bi_q  <= do_stuff ? bi_eff : bi_eff + 4'd1;
        sc_q  <= CW'(SPB - 1);
        if (bound) begin
          cur_q   <= byte_sel;
          stuff_q <= stuff_new;
          if (pre_q != '0) pre_q <= pre_q - 1'b1;
          else if (empty)  trl_q <= trl_q - 1'b1;
        end
      end else if (adv) begin
        sc_q <= sc_q - 1'b1;
      end
      if (init) begin
        busy_q <= 1'b1;
        pre_q  <= PW'(PREAMBLE_BYTES);
        cnt_q  <= '0;
        sc_q   <= '0;
        bi_q   <= 4'd8;
      end
      if (start_i) trl_q <= TW'(TRAILER_BYTES);
    end
  end

  assign sample_o       = smp_q;
  assign sample_valid_o = valid_q;
  assign busy_o         = busy_q;

  // R7
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> smp_q == 8'd0);
  // R7
  valid_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(busy_q));
  // R4
  run_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_q |-> cnt_q <= 4'(STUFF_RUN));
  // R3
  bit_counter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_q < CW'(SPB));
endmodule

// File: tb/afsk_tone_mod_bench.sv
module afsk_tone_mod_bench;
  localparam int SR  = 9600;
  localparam int PRE = 2;
  localparam int TRL = 1;
  localparam int SPB = SR / 1200;
  localparam int MK  = (512 * 1200 + SR / 2) / SR;
  localparam int SP  = (512 * 2200 + SR / 2) / SR;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic [7:0] data_i = '0;
  logic data_valid_i = 1'b0;
  logic data_ready_o, sample_valid_o, busy_o;
  logic [7:0] sample_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] pq[$];
  logic [7:0] mq[$];

  // model state
  bit m_busy, m_stuff;
  int m_inc, m_ph, m_cnt, m_bi, m_sc, m_pre, m_trl, m_smp, m_vld;
  logic [7:0] m_cur;

  afsk_tone_mod #(.SAMPLE_RATE(SR), .PREAMBLE_BYTES(PRE), .TRAILER_BYTES(TRL)) u_afsk_tone_mod (
    .clk_i, .rst_ni, .tick_i, .start_i, .data_i, .data_valid_i,
    .data_ready_o, .sample_o, .sample_valid_o, .busy_o);

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    data_valid_i <= pq.size() > 0;
    data_i       <= (pq.size() > 0) ? pq[0] : 8'h00;
  end
  always @(posedge clk_i)
    if (rst_ni && data_valid_i && data_ready_o) void'(pq.pop_front());

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R7 watchdog expired: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sine_ref(int p);
    int m, q;
    m = p % 256;
    if (m >= 128) m = 255 - m;
    q = $rtoi(128.0 + 127.0 * $sin(6.283185307179586 * m / 512.0) + 0.5);
    return (p >= 256) ? 255 - q : q;
  endfunction

  task automatic m_halt();
    m_busy = 0; m_smp = 0; m_vld = 0;
  endtask

  // one strobe of the requirement model
  task automatic m_tick();
    bit dbit;
    m_vld = 0;
    if (!m_busy) return;
    if (m_sc == 0) begin
      if (m_bi == 8) begin
        if (mq.size() == 0 && m_trl == 0) begin m_halt(); return; end
        if (!m_stuff) m_cnt = 0;
        m_stuff = 1;
        if (m_pre > 0) begin m_pre--; m_cur = 8'h7E; end
        else if (mq.size() == 0) begin m_trl--; m_cur = 8'h7E; end
        else m_cur = mq.pop_front();
        if (m_cur == 8'h1B) begin
          if (mq.size() == 0) begin m_halt(); return; end
          m_cur = mq.pop_front();
        end else if (m_cur == 8'h7E || m_cur == 8'h7F) m_stuff = 0;
        m_bi = 0;
      end
      if (m_stuff && m_cnt >= 5) begin
        m_cnt = 0; m_inc = (m_inc == MK) ? SP : MK;
      end else begin
        dbit = m_cur[m_bi];
        if (dbit) m_cnt++;
        else begin m_cnt = 0; m_inc = (m_inc == MK) ? SP : MK; end
        m_bi++;
      end
      m_sc = SPB;
    end
    m_ph = (m_ph + m_inc) % 512;
    m_sc--;
    m_smp = sine_ref(m_ph);
    m_vld = 1;
  endtask

  task automatic m_start(bit was_busy);
    if (!was_busy) begin
      m_busy = 1; m_inc = MK; m_ph = 0; m_cnt = 0; m_sc = 0; m_bi = 8; m_pre = PRE;
    end
    m_trl = TRL;
  endtask

  task automatic strobe(input string tag, input bit with_start);
    bit was;
    was = m_busy;
    @(negedge clk_i); tick_i = 1'b1; start_i = with_start;
    @(negedge clk_i); tick_i = 1'b0; start_i = 1'b0;
    m_tick();
    if (with_start) m_start(was);
    check({tag, " sample"}, sample_o, m_smp);
    check({tag, " valid"}, sample_valid_o, m_vld);
    check({tag, " busy"}, busy_o, m_busy);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic load(input logic [7:0] b);
    pq.push_back(b); mq.push_back(b);
  endtask

  task automatic kick();
    bit was;
    was = m_busy;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    m_start(was);
    check("R8 busy after start", busy_o, 1);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_frame(input string tag, input bit reload);
    int tail, n;
    bit done_reload;
    tail = 0; n = 0; done_reload = 0;
    while (tail < 3 && n < 4000) begin
      if (reload && !done_reload && m_busy && m_sc == 0 && m_bi == 8 &&
          m_pre == 0 && mq.size() == 0 && m_trl > 0) begin
        done_reload = 1;
        strobe("R8 reload", 1'b1);   // R8 reload vs trailer decrement
      end else strobe(tag, 1'b0);
      if (!m_busy) tail++;
      n++;
    end
    if (reload) check("R8 reload seen", done_reload, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 busy", busy_o, 0);
    check("R9 sample", sample_o, 0);
    check("R9 valid", sample_valid_o, 0);
    check("R9 ready", data_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 idle strobes give nothing
    strobe("R7 idle", 1'b0);
    strobe("R7 idle", 1'b0);
    // R10 buffer fills then backpressures
    load(8'hA5); load(8'h00); load(8'h3C);
    repeat (4) @(negedge clk_i);
    check("R10 ready low when full", data_ready_o, 0);
    kick();
    run_frame("R3 nrzi", 1'b0);            // R1 R2 R3 R10
    load(8'hFF); load(8'hFF); load(8'hF8);
    kick();
    run_frame("R4 stuff", 1'b0);
    load(8'hFF); load(8'h7E); load(8'h7F); load(8'hFF);
    kick();
    run_frame("R5 raw flag", 1'b0);
    load(8'h1B); load(8'h7E); load(8'h1B); load(8'h1B); load(8'hFF);
    kick();
    run_frame("R6 escape", 1'b0);
    load(8'h3C); load(8'h1B);
    kick();
    run_frame("R6 escape last", 1'b0);
    load(8'h55);
    kick();
    run_frame("R7 frame", 1'b1);           // R8 coincidence
    check("R10 input drained", pq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule